// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two binary32 operands and returns their binary32 product together with three exception flags. Each operand is split into sign, biased exponent and significand, and the hidden leading one is put back. The product sign is the XOR of the operand signs. The exponent is the sum of the two biased exponents less one bias. The two 24-bit significands form a 48-bit product. That product is normalized by at most one place, rounded to nearest with ties to even, and packed into the result word.

Special operands are resolved ahead of the arithmetic path. Any NaN operand, and any zero multiplied by infinity, give the canonical quiet NaN. Infinity times a nonzero value gives a signed infinity. A zero operand gives a signed zero. An operand with a zero exponent field is treated as zero, so denormals are flushed.

A request is presented with `mul_valid` high. The result, the flags and `res_valid` appear from one output register on the next clock edge. When `mul_valid` is low, the output register keeps its contents.

Top module: `fp32_mul_unit`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `mul_valid` high. When `mul_valid` is low, `res_word` and all three flags keep their previous values.
- R2: The sign bit (bit 31) of every non-NaN result equals the XOR of the two operand sign bits. This includes zero, infinity, overflow and underflow results.
- R3: For normal operands whose significand product is below 2, the result exponent field is Ea + Eb - 127. For example, 0x3F000000 times 0xBEE00000 gives 0xBE600000.
- R4: When the significand product is 2 or more, it is shifted right once and the exponent is incremented. For example, 0x3FC00000 squared gives 0x40100000.
- R5: Rounding is to nearest with ties to even. The guard bit is the first bit below the 24 kept bits, the round bit is the next one, and sticky is the OR of all lower bits. The result rounds up when guard is 1 and at least one of round, sticky or the kept LSB is 1.
- R6: When the rounding increment carries out of the significand, the result is renormalized. The fraction becomes zero and the exponent goes up by one. For example, 0x3FFFFFFE times 0x3F800001 gives 0x40000000.
- R7: A final biased exponent of 255 or more gives a signed infinity (exponent field all ones, fraction zero) and sets `ovf_flag`.
- R8: A final biased exponent of 0 or less gives a signed zero and sets `unf_flag`.
- R9: A NaN operand (exponent all ones, nonzero fraction), or zero times infinity, gives 0x7FC00000 and sets `inv_flag`.
- R10: Infinity times a nonzero finite value, or infinity times infinity, gives a signed infinity with no flag set.
- R11: An operand with a zero exponent field, whatever its fraction, is treated as a signed zero. Multiplying it by any finite value gives a signed zero with no flag set.
- R12: At most one of `ovf_flag`, `unf_flag` and `inv_flag` is set at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mul_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| res_valid | output | 1 | Result registered from the previous cycle's request |
| res_word | output | 32 | Binary32 product |
| ovf_flag | output | 1 | Result saturated to infinity |
| unf_flag | output | 1 | Result flushed to zero |
| inv_flag | output | 1 | Invalid operation, canonical NaN returned |

## Verification
The bench drives operand pairs chosen to land on each rounding case:
- an odd tie, which must round up;
- an even tie, which must stay;
- guard with sticky, which must round up;
- sticky without guard, which must truncate.

A rounder that ignored the kept LSB or dropped sticky would miss one of these by one unit in the last place.

A product sitting just below 2 checks the renormalization. A design that skipped it would return 0x3F800000 instead of 0x40000000.

The exponent boundaries are also covered:
- exactly 255 and exactly 0, which must saturate or flush;
- 254, which must pass through.

An off-by-one there would either leak an infinity-coded value without a flag or flush a valid number. Zero times infinity, denormal inputs and negative operands expose a wrong special-case priority or a lost sign. The hold test catches an output register that loads when `mul_valid` is low.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  parameter int EXP_W  = 8;
  parameter int FRAC_W = 23;

  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int XW     = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef struct packed {
    logic zero;
    logic inf;
    logic nan;
  } fp_class_t;

  // Round-half-even increment decision.
  function automatic logic rne_up(input logic lsb, input logic g,
                                  input logic r, input logic s);
    return g & (r | s | lsb);
  endfunction

  // Biased exponent of the product, widened so that it can go below zero
  // or past the saturation code.
  function automatic logic [XW-1:0] exp_combine(input logic [EXP_W-1:0] ea,
                                                input logic [EXP_W-1:0] eb,
                                                input logic hi,
                                                input logic carry);
    return {2'b00, ea} + {2'b00, eb} - XW'(BIAS) + XW'(hi) + XW'(carry);
  endfunction
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              sign,
  output logic [EXP_W-1:0]  expo,
  output logic [SIG_W-1:0]  sig,
  output fp_class_t         cls
);
  logic [FRAC_W-1:0] frac;
  logic              exp_max;

  assign sign    = word[WORD_W-1];
  assign expo    = word[WORD_W-2 -: EXP_W];
  assign frac    = word[FRAC_W-1:0];
  assign exp_max = &expo;

  // Hidden one restored; a zero exponent flushes to zero regardless of fraction.
  assign sig      = {1'b1, frac};
  assign cls.zero = (expo == '0);
  assign cls.inf  = exp_max && (frac == '0);
  assign cls.nan  = exp_max && (frac != '0);
endmodule

// File: rtl/fpm_sig_path.sv
module fpm_sig_path
  import fpm_pkg::*;
(
  input  logic [EXP_W-1:0]     exp_a,
  input  logic [EXP_W-1:0]     exp_b,
  input  logic [SIG_W-1:0]     sig_a,
  input  logic [SIG_W-1:0]     sig_b,
  output logic signed [XW-1:0] exp_out,
  output logic [SIG_W-1:0]     sig_out,
  output logic                 norm_shift,
  output logic                 round_inc,
  output logic                 round_carry
);
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] aligned;
  logic [SIG_W-1:0]  kept;
  logic              guard_b, round_b, sticky_b;
  logic [SIG_W:0]    summed;

  assign prod       = sig_a * sig_b;
  assign norm_shift = prod[PROD_W-1];
  // Products in [1,2) are moved up one place so both cases share one layout.
  assign aligned    = norm_shift ? prod : (prod << 1);

  assign kept     = aligned[PROD_W-1 -: SIG_W];
  assign guard_b  = aligned[PROD_W-SIG_W-1];
  assign round_b  = aligned[PROD_W-SIG_W-2];
  assign sticky_b = |aligned[PROD_W-SIG_W-3:0];

  assign round_inc   = rne_up(kept[0], guard_b, round_b, sticky_b);
  assign summed      = {1'b0, kept} + {{SIG_W{1'b0}}, round_inc};
  assign round_carry = summed[SIG_W];
  assign sig_out     = round_carry ? summed[SIG_W:1] : summed[SIG_W-1:0];
  assign exp_out     = $signed(exp_combine(exp_a, exp_b, norm_shift, round_carry));
endmodule

// File: rtl/fp32_mul_unit.sv
module fp32_mul_unit
  import fpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mul_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic              ovf_flag,
  output logic              unf_flag,
  output logic              inv_flag
);
  localparam logic signed [XW-1:0] EXP_SAT  = XW'((1 << EXP_W) - 1);
  localparam logic signed [XW-1:0] EXP_NONE = '0;
  localparam logic [WORD_W-1:0]    QNAN     = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic             sgn_a, sgn_b, sgn_p;
  logic [EXP_W-1:0] ex_a, ex_b;
  logic [SIG_W-1:0] sg_a, sg_b;
  fp_class_t        cl_a, cl_b;

  logic signed [XW-1:0] exp_fin;
  logic [SIG_W-1:0]     sig_fin;
  logic                 norm_shift, round_inc, round_carry;

  logic                 any_nan, any_zero, any_inf, path_normal;
  logic [WORD_W-1:0]    nxt_word;
  logic                 nxt_ovf, nxt_unf, nxt_inv;

  fpm_unpack u_unp_a (.word(op_a), .sign(sgn_a), .expo(ex_a), .sig(sg_a), .cls(cl_a));
  fpm_unpack u_unp_b (.word(op_b), .sign(sgn_b), .expo(ex_b), .sig(sg_b), .cls(cl_b));

  fpm_sig_path u_sig (
    .exp_a(ex_a), .exp_b(ex_b), .sig_a(sg_a), .sig_b(sg_b),
    .exp_out(exp_fin), .sig_out(sig_fin),
    .norm_shift(norm_shift), .round_inc(round_inc), .round_carry(round_carry)
  );

  assign sgn_p       = sgn_a ^ sgn_b;
  assign any_nan     = cl_a.nan | cl_b.nan;
  assign any_zero    = cl_a.zero | cl_b.zero;
  assign any_inf     = cl_a.inf | cl_b.inf;
  assign path_normal = !any_nan && !any_zero && !any_inf;

  always_comb begin
    nxt_ovf = 1'b0;
    nxt_unf = 1'b0;
    nxt_inv = 1'b0;
    if (any_nan || (any_zero && any_inf)) begin
      nxt_word = QNAN;
      nxt_inv  = 1'b1;
    end else if (any_inf) begin
      nxt_word = {sgn_p, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (any_zero) begin
      nxt_word = {sgn_p, {(WORD_W-1){1'b0}}};
    end else if (exp_fin >= EXP_SAT) begin
      nxt_word = {sgn_p, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      nxt_ovf  = 1'b1;
    end else if (exp_fin <= EXP_NONE) begin
      nxt_word = {sgn_p, {(WORD_W-1){1'b0}}};
      nxt_unf  = 1'b1;
    end else begin
      nxt_word = {sgn_p, exp_fin[EXP_W-1:0], sig_fin[FRAC_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
      ovf_flag  <= 1'b0;
      unf_flag  <= 1'b0;
      inv_flag  <= 1'b0;
    end else begin
      res_valid <= mul_valid;
      if (mul_valid) begin
        res_word <= nxt_word;
        ovf_flag <= nxt_ovf;
        unf_flag <= nxt_unf;
        inv_flag <= nxt_inv;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mul_valid |=> res_valid); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mul_valid |=> (!res_valid && $stable(res_word) && $stable({ovf_flag, unf_flag, inv_flag}))); // R1
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !inv_flag) |-> (res_word[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1]))); // R2
  AST_RENORM_LEADING_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    path_normal |-> sig_fin[SIG_W-1]); // R6
  AST_CARRY_NEEDS_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (path_normal && round_carry) |-> (round_inc && sig_fin[SIG_W-2:0] == '0)); // R6
  AST_OVERFLOW_INF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> (res_word[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})); // R7
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |-> (res_word[WORD_W-2:0] == '0)); // R8
  AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
    inv_flag |-> (res_word == QNAN)); // R9
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ovf_flag, unf_flag, inv_flag}) <= 1); // R12
endmodule

// File: tb/fp32_mul_unit_bench.sv
module fp32_mul_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mul_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        res_valid;
  logic [31:0] res_word;
  logic        ovf_flag, unf_flag, inv_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fp32_mul_unit u_fp32_mul_unit (
    .clk(clk), .rst_n(rst_n), .mul_valid(mul_valid), .op_a(op_a), .op_b(op_b),
    .res_valid(res_valid), .res_word(res_word),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .inv_flag(inv_flag)
  );

  task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Flags packed as {ovf, unf, inv}; the valid bit sits above them.
  task automatic mul_case(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp_word, input logic [2:0] exp_flags);
    @(negedge clk);
    op_a = a; op_b = b; mul_valid = 1'b1;
    @(negedge clk);
    mul_valid = 1'b0;
    check(req, {res_valid, ovf_flag, unf_flag, inv_flag, res_word},
          {1'b1, exp_flags, exp_word});
  endtask

  task automatic test_reset();
    check("R1 reset", {res_valid, ovf_flag, unf_flag, inv_flag, res_word}, 36'h0);
  endtask

  task automatic test_exponent();
    mul_case("R3 half times -0.4375", 32'h3F000000, 32'hBEE00000, 32'hBE600000, 3'b000);
    mul_case("R3 one times three", 32'h3F800000, 32'h40400000, 32'h40400000, 3'b000);
  endtask

  task automatic test_hold();
    @(negedge clk);
    op_a = 32'h7FC00001; op_b = 32'h00000000; mul_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 idle hold", {res_valid, ovf_flag, unf_flag, inv_flag, res_word},
          {1'b0, 3'b000, 32'h40400000});
  endtask

  task automatic test_shift();
    mul_case("R4 1.5 squared", 32'h3FC00000, 32'h3FC00000, 32'h40100000, 3'b000);
  endtask

  task automatic test_sign();
    mul_case("R2 neg times neg", 32'hC0000000, 32'hC0400000, 32'h40C00000, 3'b000);
    mul_case("R2 pos times neg zero", 32'h40400000, 32'h80000000, 32'h80000000, 3'b000);
  endtask

  task automatic test_round();
    mul_case("R5 tie odd rounds up", 32'h3F800001, 32'h3FC00000, 32'h3FC00002, 3'b000);
    mul_case("R5 tie even stays", 32'h3F800003, 32'h3FC00000, 32'h3FC00004, 3'b000);
    mul_case("R5 guard plus sticky up", 32'h3F800003, 32'h3FC00001, 32'h3FC00006, 3'b000);
    mul_case("R5 sticky only truncates", 32'h3F800001, 32'h3F800001, 32'h3F800002, 3'b000);
  endtask

  task automatic test_renorm();
    mul_case("R6 rounding carry", 32'h3FFFFFFE, 32'h3F800001, 32'h40000000, 3'b000);
  endtask

  task automatic test_overflow();
    mul_case("R7 exponent 255", 32'h7F000000, 32'h40000000, 32'h7F800000, 3'b100);
    mul_case("R7 negative overflow", 32'hFF000000, 32'h40000000, 32'hFF800000, 3'b100);
    mul_case("R7 exponent 254 passes", 32'h7F000000, 32'h3F800000, 32'h7F000000, 3'b000);
  endtask

  task automatic test_underflow();
    mul_case("R8 exponent 0", 32'h00800000, 32'h3F000000, 32'h00000000, 3'b010);
    mul_case("R8 negative underflow", 32'h80800000, 32'h3F000000, 32'h80000000, 3'b010);
    mul_case("R8 exponent 1 passes", 32'h00800000, 32'h3F800000, 32'h00800000, 3'b000);
  endtask

  task automatic test_invalid();
    mul_case("R9 zero times inf", 32'h00000000, 32'h7F800000, 32'h7FC00000, 3'b001);
    mul_case("R9 nan operand", 32'hFFC12345, 32'h3F800000, 32'h7FC00000, 3'b001);
    mul_case("R9 denormal times inf", 32'h00400000, 32'hFF800000, 32'h7FC00000, 3'b001);
  endtask

  task automatic test_infinity();
    mul_case("R10 inf times neg finite", 32'h7F800000, 32'hC0000000, 32'hFF800000, 3'b000);
    mul_case("R10 inf times inf", 32'hFF800000, 32'hFF800000, 32'h7F800000, 3'b000);
  endtask

  task automatic test_denormal();
    mul_case("R11 denormal flushed", 32'h00400000, 32'h3F800000, 32'h00000000, 3'b000);
    mul_case("R11 neg denormal flushed", 32'h807FFFFF, 32'h7F000000, 32'h80000000, 3'b000);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_exponent();
    test_hold();
    test_shift();
    test_sign();
    test_round();
    test_renorm();
    test_overflow();
    test_underflow();
    test_invalid();
    test_infinity();
    test_denormal();
    // R12 exclusivity follows from every flag vector above carrying at most one bit.
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule